// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is a single-master I2C controller that software steers one step at a time. A command write asks for any mix of a START condition, one byte sent, one byte received (optionally the final byte of a read) and a STOP condition. The engine carries out that step on open-drain SCL and SDA lines, then raises a sticky status flag saying how the step ended. Software clears these flags by writing ones to them.

The byte to send sits in the low half of a 16-bit transfer buffer. A received byte lands in the upper half, so the outgoing byte stays where it is. The bus is timed by a quarter-bit prefix divider, so one bit takes four ticks. The resynchronised levels of both bus lines are always visible. A master-enable bit gates the whole engine. Writing it to zero stops any transfer at once, releases both lines and clears all flags.

Top module: `i2cm_engine`

## Requirements
- R1: A command with the start bit (cmd_bits[0]) and the transmit bit (cmd_bits[1]) both set produces a START condition (SDA falls while SCL is high) and then shifts out xfer_buf[7:0] MSB first. That byte is the 7-bit address shifted left by one with the R/W bit in bit 0.
- R2: After a transmit, the engine samples SDA on the ninth clock. It sets flags[0] (acknowledged) if SDA was low, or flags[1] (not acknowledged) if SDA was high, and never sets both.
- R3: A receive command (cmd_bits[2]) clocks in eight bits MSB first and drives ACK (SDA low) on the ninth clock. It then places the byte in xfer_buf[15:8] and sets flags[2]. xfer_buf[7:0] is left unchanged.
- R4: A receive command that also carries the last bit (cmd_bits[3]) leaves SDA released on the ninth clock, so the master answers with NAK.
- R5: A stop command (cmd_bits[4]) forms a STOP condition (SDA rises while SCL is high) and sets flags[3] when it completes. Afterwards both lines are released high.
- R6: The flags are sticky. A clear write sets to zero exactly the flags whose clr_mask bit is one, and an all-ones mask clears all five.
- R7: line_scl and line_sda follow the bus levels scl_in and sda_in after a two-stage synchroniser. After reset both read 1.
- R8: Writing fn_we with fn_en=0 returns the engine to idle at once, releases both lines and clears all flags. Any command issued while the engine is disabled is not carried out and sets flags[4] (abnormal).
- R9: busy rises in the cycle after a command is accepted and falls when the step's completion flag is set. Commands issued while busy is high are ignored and set no flag.
- R10: A command with both the transmit and receive bits set is rejected. It starts no bus activity and sets flags[4].
- R11: The engine changes its SDA drive only while it holds SCL low, except inside the START and STOP sequences.
- R12: Bits combined in one command run in the order START, byte, STOP. A START+transmit+STOP command sets both flags[0] and flags[3] and leaves the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_we | input | 1 | Write strobe for the master-enable bit |
| fn_en | input | 1 | Master-enable value; 0 resets the engine |
| cmd_we | input | 1 | Command write strobe |
| cmd_bits | input | 5 | [0] start, [1] transmit, [2] receive, [3] last, [4] stop |
| txb_we | input | 1 | Write strobe for the transmit byte |
| txb_data | input | 8 | Transmit byte value |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 5 | Ones select flags to clear |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A command step is in progress |
| flags | output | 5 | [0] tx ack, [1] tx nak, [2] rx done, [3] stop done, [4] abnormal |
| xfer_buf | output | 16 | [15:8] received byte, [7:0] transmit byte |
| line_scl | output | 1 | Synchronised SCL level |
| line_sda | output | 1 | Synchronised SDA level |

## Verification
The bench pairs the engine with a behavioural slave that decodes START, STOP, address and data. It targets these corner cases:
- An address nobody answers. A design that reads the acknowledge slot wrongly would report ACK.
- A receive-last byte. If the last bit is dropped, the slave sees ACK and keeps driving.
- A stop command sent while a byte is still running. An engine that accepts it would emit a STOP and raise the stop flag early.
- A partial clear mask. A design that clears every flag would lose the stop flag.
- A transmit+receive command. Letting it through would clock the bus.
- A disable in the middle of a transfer. If the lines were left driven, SCL would stay low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int FLAG_N   = 5;
  localparam int F_TXACK  = 0;
  localparam int F_TXNAK  = 1;
  localparam int F_RXDONE = 2;
  localparam int F_STOP   = 3;
  localparam int F_ABN    = 4;

  localparam int CMD_N    = 5;
  localparam int C_START  = 0;
  localparam int C_TX     = 1;
  localparam int C_RX     = 2;
  localparam int C_LAST   = 3;
  localparam int C_STOP   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_TAIL,
    ST_STOP
  } eng_st_t;

  // transmit and receive in the same step cannot both be honoured
  function automatic logic cmd_conflict(input logic [CMD_N-1:0] c);
    return c[C_TX] && c[C_RX];
  endfunction

  // a command must ask for at least one bus action
  function automatic logic cmd_has_action(input logic [CMD_N-1:0] c);
    return c[C_START] || c[C_TX] || c[C_RX] || c[C_STOP];
  endfunction

  // pull-down on SDA for data bit i (0 = MSB) of a transmitted byte
  function automatic logic data_pull(input logic is_tx, input logic [7:0] b,
                                     input logic [2:0] i);
    return is_tx && !b[3'd7 - i];
  endfunction

  // pull-down on SDA in the acknowledge slot of a received byte
  function automatic logic ack_pull(input logic is_rx, input logic is_last);
    return is_rx && !is_last;
  endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[g] <= '1;
      else if (g == 0) stg[g] <= din;
      else             stg[g] <= stg[(g == 0) ? 0 : g - 1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q[i] <= 1'b0;
      else if (clr_all)                q[i] <= 1'b0;
      else if (set_vec[i])             q[i] <= 1'b1;
      else if (clr_we && clr_mask[i])  q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int QTR_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fn_we,
  input  logic                fn_en,
  input  logic                cmd_we,
  input  logic [CMD_N-1:0]    cmd_bits,
  input  logic                txb_we,
  input  logic [BYTE_W-1:0]   txb_data,
  input  logic                clr_we,
  input  logic [FLAG_N-1:0]   clr_mask,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                scl_oe,
  output logic                sda_oe,
  output logic                busy,
  output logic [FLAG_N-1:0]   flags,
  output logic [2*BYTE_W-1:0] xfer_buf,
  output logic                line_scl,
  output logic                line_sda
);
  localparam int BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_IDX = BW'(BYTE_W);

  // ---------------- state ----------------
  eng_st_t            st;
  logic [1:0]         ph;
  logic [BW-1:0]      bidx;
  logic               en_q;
  logic               l_start, l_tx, l_rx, l_last, l_stop;
  logic [BYTE_W-1:0]  txb, l_txb, rsh, rxb;
  logic               ack_q;
  logic               scl_oe_q, sda_oe_q;

  // ---------------- named events ----------------
  logic               kill, cmd_acc, cmd_bad, tick;
  logic               byte_fin, stop_fin, cond_zone;
  logic               sda_s, scl_s;
  logic [FLAG_N-1:0]  set_vec;
  logic               clr_all;

  assign busy      = (st != ST_IDLE);
  assign kill      = !en_q || (fn_we && !fn_en);
  assign clr_all   = fn_we && !fn_en;
  assign cmd_acc   = cmd_we && !busy && !kill && !cmd_conflict(cmd_bits)
                     && cmd_has_action(cmd_bits);
  assign cmd_bad   = cmd_we && !busy && (!en_q || cmd_conflict(cmd_bits));
  assign byte_fin  = tick && (st == ST_TAIL);
  assign stop_fin  = tick && (st == ST_STOP) && (ph == 2'd3);
  assign cond_zone = (st == ST_START) || (st == ST_STOP);

  always_comb begin
    set_vec           = '0;
    set_vec[F_TXACK]  = byte_fin && l_tx && !ack_q;
    set_vec[F_TXNAK]  = byte_fin && l_tx &&  ack_q;
    set_vec[F_RXDONE] = byte_fin && l_rx;
    set_vec[F_STOP]   = stop_fin;
    set_vec[F_ABN]    = cmd_bad;
  end

  // ---------------- sub-blocks ----------------
  i2cm_qtick #(.DIV(QTR_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout ({scl_s, sda_s})
  );

  i2cm_flags #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .clr_we  (clr_we),
    .clr_mask(clr_mask),
    .set_vec (set_vec),
    .q       (flags)
  );

  // ---------------- enable and transmit buffer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      txb  <= '0;
    end else begin
      if (fn_we)  en_q <= fn_en;
      if (txb_we) txb  <= txb_data;
    end
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= '0;
      bidx     <= '0;
      l_start  <= 1'b0;
      l_tx     <= 1'b0;
      l_rx     <= 1'b0;
      l_last   <= 1'b0;
      l_stop   <= 1'b0;
      l_txb    <= '0;
      rsh      <= '0;
      rxb      <= '0;
      ack_q    <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (kill) begin
      st       <= ST_IDLE;
      ph       <= '0;
      bidx     <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (cmd_acc) begin
      l_start <= cmd_bits[C_START];
      l_tx    <= cmd_bits[C_TX];
      l_rx    <= cmd_bits[C_RX];
      l_last  <= cmd_bits[C_LAST];
      l_stop  <= cmd_bits[C_STOP];
      l_txb   <= txb;
      ph      <= '0;
      bidx    <= '0;
      if (cmd_bits[C_START])                   st <= ST_START;
      else if (cmd_bits[C_TX] || cmd_bits[C_RX]) st <= ST_BIT;
      else                                     st <= ST_STOP;
    end else if (tick) begin
      ph <= ph + 2'd1;
      unique case (st)
        ST_START: begin
          unique case (ph)
            2'd0: sda_oe_q <= 1'b0;
            2'd1: scl_oe_q <= 1'b0;
            2'd2: sda_oe_q <= 1'b1;
            default: begin
              scl_oe_q <= 1'b1;
              bidx     <= '0;
              if (l_tx || l_rx) st <= ST_BIT;
              else if (l_stop)  st <= ST_STOP;
              else              st <= ST_IDLE;
            end
          endcase
        end
        ST_BIT: begin
          unique case (ph)
            2'd0: sda_oe_q <= (bidx == ACK_IDX) ? ack_pull(l_rx, l_last)
                              : data_pull(l_tx, l_txb, bidx[2:0]);
            2'd1: scl_oe_q <= 1'b0;
            2'd2: begin
              if (bidx == ACK_IDX) ack_q <= sda_s;
              else                 rsh   <= {rsh[BYTE_W-2:0], sda_s};
            end
            default: begin
              scl_oe_q <= 1'b1;
              if (bidx == ACK_IDX) begin
                st <= ST_TAIL;
                ph <= '0;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end
          endcase
        end
        ST_TAIL: begin
          sda_oe_q <= 1'b0;
          ph       <= '0;
          if (l_rx) rxb <= rsh;
          st <= l_stop ? ST_STOP : ST_IDLE;
        end
        ST_STOP: begin
          unique case (ph)
            2'd0: scl_oe_q <= 1'b1;
            2'd1: sda_oe_q <= 1'b1;
            2'd2: scl_oe_q <= 1'b0;
            default: begin
              sda_oe_q <= 1'b0;
              st       <= ST_IDLE;
            end
          endcase
        end
        default: ph <= '0;
      endcase
    end
  end

  assign scl_oe   = scl_oe_q;
  assign sda_oe   = sda_oe_q;
  assign xfer_buf = {rxb, txb};
  assign line_scl = scl_s;
  assign line_sda = sda_s;

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
  import i2cm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              busy,
  input logic              cmd_we,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              cond_zone,
  input logic              byte_fin,
  input logic              stop_fin,
  input logic              clr_we,
  input logic              clr_all,
  input logic [FLAG_N-1:0] clr_mask,
  input logic [FLAG_N-1:0] set_vec,
  input logic [FLAG_N-1:0] flags
);
  // R8: a disabled engine drives nothing and is idle
  a_r8_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!scl_oe && !sda_oe && !busy));

  // R9: a step only starts after a command write
  a_r9_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we));

  // R9: the engine is idle right after a stop completes
  a_r9_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fin |=> !busy);

  // R11: SDA drive moves only under a held-low SCL outside START/STOP
  a_r11_sda_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (sda_oe != $past(sda_oe)) && !$past(cond_zone))
      |-> ($past(scl_oe) && scl_oe));

  // R5: the stop flag rises only from a completed STOP sequence
  a_r5_stop_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_STOP]) |-> $past(stop_fin));

  // R3: a byte completes with SCL held low
  a_r3_byte_end_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fin |-> scl_oe);

  // R6: selected flags read zero after a clear unless set again
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !clr_all) |=> ((flags & $past(clr_mask & ~set_vec)) == '0));
endmodule

bind i2cm_engine i2cm_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_q     (en_q),
  .busy     (busy),
  .cmd_we   (cmd_we),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .cond_zone(cond_zone),
  .byte_fin (byte_fin),
  .stop_fin (stop_fin),
  .clr_we   (clr_we),
  .clr_all  (clr_all),
  .clr_mask (clr_mask),
  .set_vec  (set_vec),
  .flags    (flags)
);

// File: tb/sim_i2cm_engine.sv
module sim_i2cm_engine;
  localparam int CLK_T = 10;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fn_we = 0, fn_en = 0, cmd_we = 0, txb_we = 0, clr_we = 0;
  logic [4:0] cmd_bits = '0, clr_mask = '0;
  logic [7:0] txb_data = '0;
  logic scl_oe, sda_oe, busy, line_scl, line_sda;
  logic [4:0] flags;
  logic [15:0] xfer_buf;
  logic s_sda_oe = 1'b0;
  logic scl_bus, sda_bus;

  int total = 0, bad = 0;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || s_sda_oe);

  always #(CLK_T/2) clk = ~clk;

  i2cm_engine u0 (
    .clk(clk), .rst_n(rst_n), .fn_we(fn_we), .fn_en(fn_en),
    .cmd_we(cmd_we), .cmd_bits(cmd_bits), .txb_we(txb_we), .txb_data(txb_data),
    .clr_we(clr_we), .clr_mask(clr_mask), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .flags(flags),
    .xfer_buf(xfer_buf), .line_scl(line_scl), .line_sda(line_sda)
  );

  // ---------------- behavioural slave ----------------
  logic p_scl = 1'b1, p_sda = 1'b1;
  int s_mode = 0, s_bit = 0, s_starts = 0, s_stops = 0, s_ridx = 0, s_logn = 0;
  logic [7:0] s_sh = '0, s_tx = '0, s_last = '0;
  logic s_ackd = 0, s_rw = 0, s_mack = 0;
  logic [7:0] rd_data [2] = '{8'hC5, 8'h3A};

  always @(scl_bus or sda_bus) begin
    if (scl_bus && p_scl && p_sda && !sda_bus) begin
      s_mode = 1; s_bit = -1; s_sda_oe = 0; s_starts++;
    end else if (scl_bus && p_scl && !p_sda && sda_bus) begin
      s_mode = 0; s_sda_oe = 0; s_stops++;
    end else if (scl_bus && !p_scl) begin
      if ((s_mode == 1 || s_mode == 2) && s_bit >= 0 && s_bit < 8)
        s_sh = {s_sh[6:0], sda_bus};
      if (s_mode == 3 && s_bit == 8) s_mack = sda_bus;
    end else if (!scl_bus && p_scl && s_mode != 0) begin
      s_bit++;
      if (s_bit == 8) begin
        if (s_mode == 1) begin
          s_rw = s_sh[0]; s_ackd = (s_sh[7:1] == SLV); s_sda_oe = s_ackd;
          s_last = s_sh; s_logn++;
        end else if (s_mode == 2) begin
          s_last = s_sh; s_logn++; s_sda_oe = 1;
        end else s_sda_oe = 0;
      end else if (s_bit == 9) begin
        s_bit = 0; s_sda_oe = 0;
        if (s_mode == 1) begin
          if (!s_ackd) s_mode = 0;
          else if (s_rw) begin
            s_mode = 3; s_tx = rd_data[s_ridx % 2]; s_ridx++; s_sda_oe = !s_tx[7];
          end else s_mode = 2;
        end else if (s_mode == 3) begin
          if (s_mack) s_mode = 0;
          else begin
            s_tx = rd_data[s_ridx % 2]; s_ridx++; s_sda_oe = !s_tx[7];
          end
        end
      end else if (s_mode == 3 && s_bit >= 1 && s_bit <= 7) begin
        s_sda_oe = !s_tx[7 - s_bit];
      end
    end
    p_scl = scl_bus; p_sda = sda_bus;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); txb_we = 1; txb_data = b;
    @(negedge clk); txb_we = 0;
  endtask

  task automatic issue(input logic [4:0] c);
    @(negedge clk); cmd_we = 1; cmd_bits = c;
    @(negedge clk); cmd_we = 0; cmd_bits = '0;
  endtask

  task automatic clear(input logic [4:0] m);
    @(negedge clk); clr_we = 1; clr_mask = m;
    @(negedge clk); clr_we = 0; clr_mask = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R7 reset line_scl", line_scl, 1);
    chk("R7 reset line_sda", line_sda, 1);
    chk("R8 reset flags", flags, 0);
    chk("R9 reset busy", busy, 0);
    chk("R8 reset oe", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write();
    int st0;
    st0 = s_starts;
    put_byte({SLV, 1'b0});
    issue(5'b00011);
    chk("R9 busy after accept", busy, 1);
    wait_idle();
    chk("R1 start seen", s_starts, st0 + 1);
    chk("R1 address byte", s_last, {SLV, 1'b0});
    chk("R2 address ack flag", flags, 5'b00001);
    clear(5'h1F);
    put_byte(8'hA7);
    issue(5'b00010);
    wait_idle();
    chk("R2 data byte", s_last, 8'hA7);
    chk("R2 data ack flag", flags, 5'b00001);
    chk("R7 line_scl held low", line_scl, 0);
    issue(5'b10000);
    wait_idle();
    chk("R5 stop flag", flags, 5'b01001);
    chk("R5 lines released", {line_scl, line_sda}, 2'b11);
    clear(5'b00001);
    chk("R6 partial clear keeps stop", flags, 5'b01000);
    clear(5'h1F);
    chk("R6 clear all", flags, 0);
  endtask

  task automatic t_nak();
    put_byte({7'h33, 1'b0});
    issue(5'b10011);
    wait_idle();
    chk("R2 nak flag R12 stop", flags, 5'b01010);
    chk("R12 bus released", {line_scl, line_sda}, 2'b11);
    clear(5'h1F);
  endtask

  task automatic t_read();
    put_byte({SLV, 1'b1});
    issue(5'b00011);
    wait_idle();
    chk("R1 read address ack", flags, 5'b00001);
    clear(5'h1F);
    issue(5'b00100);
    wait_idle();
    chk("R3 rx done", flags, 5'b00100);
    chk("R3 rx byte", xfer_buf[15:8], 8'hC5);
    chk("R3 tx field kept", xfer_buf[7:0], {SLV, 1'b1});
    chk("R3 master ack", s_mack, 0);
    clear(5'h1F);
    issue(5'b01100);
    wait_idle();
    chk("R4 last byte", xfer_buf[15:8], 8'h3A);
    chk("R4 master nak", s_mack, 1);
    issue(5'b10000);
    wait_idle();
    chk("R4 flags", flags, 5'b01100);
    clear(5'h1F);
  endtask

  task automatic t_busy_ignore();
    int sp0;
    sp0 = s_stops;
    put_byte({SLV, 1'b0});
    issue(5'b00011);
    repeat (5) @(negedge clk);
    issue(5'b10000);
    wait_idle();
    chk("R9 ignored stop flags", flags, 5'b00001);
    chk("R9 no stop on bus", s_stops, sp0);
    chk("R9 scl still low", line_scl, 0);
    issue(5'b10000);
    wait_idle();
    chk("R5 stop after ignore", s_stops, sp0 + 1);
    clear(5'h1F);
  endtask

  task automatic t_conflict();
    issue(5'b00110);
    chk("R10 not busy", busy, 0);
    @(negedge clk);
    chk("R10 abnormal", flags, 5'b10000);
    chk("R10 bus idle", {scl_oe, sda_oe}, 0);
    clear(5'h1F);
  endtask

  task automatic t_disable();
    put_byte({SLV, 1'b0});
    issue(5'b00011);
    repeat (40) @(negedge clk);
    @(negedge clk); fn_we = 1; fn_en = 0;
    @(negedge clk); fn_we = 0;
    chk("R8 idle after disable", busy, 0);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    chk("R8 flags cleared", flags, 0);
    issue(5'b00011);
    chk("R8 disabled not busy", busy, 0);
    @(negedge clk);
    chk("R8 abnormal when off", flags, 5'b10000);
  endtask

  initial begin
    #(CLK_T * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); fn_we = 1; fn_en = 1;
    @(negedge clk); fn_we = 0;
    t_write();
    t_nak();
    t_read();
    t_busy_ignore();
    t_conflict();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule